// File: doc/BRIEF.md
# Host Ring Flow Controller with Overrun Reporting

This block sits between a capture channel's ping-pong buffers and a ring of host-memory buffers. It decides which ring entry each buffer transfer goes to. It keeps a hardware write index that advances on each completed transfer and a host read index that software updates. It refuses to issue a transfer into an entry the host has not yet consumed, and it raises a one-cycle interrupt for every completed transfer.

When a buffer cannot be placed, because the ring is full or a transfer is still in flight, the block enters overrun mode. In overrun mode it discards whole incoming records at ingress. It counts the lost buffers, the dropped records and the dropped bytes, and each count saturates. Once the ring has room again and no transfer is active, the block holds back the next incoming record. It first inserts a six-word overrun report into the outgoing stream. The report has the same layout as a captured record: timestamp, status word, then the three loss counts.

Top module: `ring_flow_ctrl`

## Requirements
- R1: After reset the ring size reads RING_MAX, the read and write indices read 0, and neither xfer_start_o nor irq_o is asserted.
- R2: Register port: address 0 is the ring size, clamped on write into [2, RING_MAX]. Address 1 is the host read index; a written value not below the ring size is taken as 0. Address 2 is the write index and is read-only. Address 3 reads zero. reg_rdata_o is combinational.
- R3: A buf_req_i pulse while no transfer is in flight and the ring is not full asserts xfer_start_o in the same cycle. xfer_idx_o carries (write index + 1) modulo the ring size.
- R4: On the clock edge that samples xfer_done_i during a transfer, the write index takes the started index. irq_o is then high for exactly one cycle.
- R5: The ring is full when (write index + 1) modulo size equals the read index. A request made while the ring is full or a transfer is in flight starts nothing, is counted as a lost buffer, and enters overrun mode.
- R6: In overrun mode, a record whose first word arrives is discarded in full: in_ready_o is high and nothing is output. The frame count rises by 1 and the byte count rises by 4 per discarded word.
- R7: The loss counts saturate at 2^CNT_W-1.
- R8: Overrun mode ends in the first cycle where the ring is not full and no transfer is in flight. A report then becomes pending.
- R9: A pending report is emitted before the next record, while the input is stalled. Its six words are: time_i[63:32] and time_i[31:0] (captured in the cycle the report starts), status 0x2000000C (bit 29 = overrun flag, bits 11:0 = length 12), lost buffers, dropped frames, dropped bytes. out_first_o marks word 0 and out_last_o marks word 5.
- R10: The loss counts return to zero when a report starts, so the next report counts only later losses.
- R11: With no overrun and no pending report, records pass through unchanged with their first and last marks.
- R12: While out_ready_i is low during a report, out_valid_o stays high and out_data_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current relative time |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| buf_req_i | input | 1 | A ping-pong buffer is ready for transfer |
| xfer_done_i | input | 1 | The current transfer has completed |
| xfer_start_o | output | 1 | Start a transfer into ring entry xfer_idx_o |
| xfer_idx_o | output | IDX_W | Target ring entry |
| irq_o | output | 1 | Per-transfer interrupt pulse |
| in_valid_i | input | 1 | Ingress word valid |
| in_first_i | input | 1 | Ingress word is first of a record |
| in_last_i | input | 1 | Ingress word is last of a record |
| in_data_i | input | 32 | Ingress word |
| in_ready_o | output | 1 | Ingress word accepted |
| out_valid_o | output | 1 | Egress word valid |
| out_first_o | output | 1 | Egress word is first of a record |
| out_last_o | output | 1 | Egress word is last of a record |
| out_data_o | output | 32 | Egress word |
| out_ready_i | input | 1 | Egress word taken |

## Verification
The bench builds the block with RING_MAX = 8 and CNT_W = 4. Programming a ring size of 4 lets a few transfers fill the ring, and it makes the wrap of the write index to entry 0 reachable. A 4-bit count reaches saturation after 15 dropped records or four dropped words. This exercises both saturation paths, and the clearing between two successive reports, within a few hundred cycles.

// File: rtl/ring_flow_pkg.sv
package ring_flow_pkg;
  localparam int unsigned RPT_WORDS = 6;
  localparam int unsigned OVR_BIT   = 29;
  localparam int unsigned RPT_LEN   = 12;
  localparam logic [31:0] RPT_STATUS = (32'd1 << OVR_BIT) | 32'(RPT_LEN);

  typedef enum logic [1:0] {
    REG_SIZE = 2'd0,
    REG_RD   = 2'd1,
    REG_WR   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_PASS,
    ST_RPT
  } ins_state_e;
endpackage

// File: rtl/ring_idx_unit.sv
module ring_idx_unit
  import ring_flow_pkg::*;
#(
  parameter int unsigned RING_MAX = 512,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned SZ_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             buf_req_i,
  input  logic             xfer_done_i,
  output logic             xfer_start_o,
  output logic [IDX_W-1:0] xfer_idx_o,
  output logic             irq_o,
  output logic             lost_o,
  output logic             space_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(RING_MAX);

  logic [SZ_W-1:0]  size_q;
  logic [IDX_W-1:0] wr_q, rd_q, cur_q;
  logic             busy_q, irq_q;
  logic [SZ_W-1:0]  inc;
  logic [IDX_W-1:0] next_idx;
  logic             full;
  reg_sel_e         sel;

  always_comb begin
    inc      = SZ_W'(wr_q) + SZ_W'(1);
    next_idx = (inc >= size_q) ? '0 : inc[IDX_W-1:0];
    full     = (next_idx == rd_q);
  end

  assign xfer_start_o = buf_req_i & ~busy_q & ~full;
  assign xfer_idx_o   = next_idx;
  assign lost_o       = buf_req_i & (busy_q | full);
  assign space_o      = ~busy_q & ~full;
  assign irq_o        = irq_q;
  assign rd_idx_o     = rd_q;
  assign sel          = reg_sel_e'(reg_addr_i);

  always_comb begin
    unique case (sel)
      REG_SIZE: reg_rdata_o = 32'(size_q);
      REG_RD:   reg_rdata_o = 32'(rd_q);
      REG_WR:   reg_rdata_o = 32'(wr_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_MAX;
      rd_q   <= '0;
      wr_q   <= '0;
      cur_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (reg_we_i && sel == REG_SIZE) begin
        if (reg_wdata_i < 32'd2)                 size_q <= SZ_W'(2);
        else if (reg_wdata_i > 32'(RING_MAX))    size_q <= SZ_MAX;
        else                                     size_q <= SZ_W'(reg_wdata_i);
      end
      if (reg_we_i && sel == REG_RD)
        rd_q <= (reg_wdata_i >= 32'(size_q)) ? '0 : IDX_W'(reg_wdata_i);
      if (xfer_start_o) begin
        busy_q <= 1'b1;
        cur_q  <= next_idx;
      end else if (busy_q && xfer_done_i) begin
        busy_q <= 1'b0;
        wr_q   <= cur_q;
        irq_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] LIM = MAX - W'(STEP);

  logic [W-1:0] q, base;

  assign base  = clr_i ? '0 : q;
  assign cnt_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (inc_i)  q <= (base > LIM) ? MAX : base + W'(STEP);
    else             q <= base;
  end
endmodule

// File: rtl/loss_acct.sv
module loss_acct #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lost_i,
  input  logic             space_i,
  input  logic             drop_frame_i,
  input  logic             drop_word_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] bufs_o,
  output logic [CNT_W-1:0] frames_o,
  output logic [CNT_W-1:0] bytes_o,
  output logic             ovr_o,
  output logic             pending_o
);
  logic             ovr_q, pend_q;
  logic [2:0]       inc_v;
  logic [CNT_W-1:0] cnt_v [3];

  assign inc_v = {drop_word_i, drop_frame_i, lost_i};

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    sat_counter #(.W(CNT_W), .STEP((g == 2) ? 4 : 1)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (snap_i),
      .inc_i (inc_v[g]),
      .cnt_o (cnt_v[g])
    );
  end

  assign bufs_o    = cnt_v[0];
  assign frames_o  = cnt_v[1];
  assign bytes_o   = cnt_v[2];
  assign ovr_o     = ovr_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (lost_i)               ovr_q <= 1'b1;
      else if (ovr_q && space_i) ovr_q <= 1'b0;
      if (ovr_q && space_i && !lost_i) pend_q <= 1'b1;
      else if (snap_i)                 pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stream_insert.sv
module stream_insert
  import ring_flow_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      time_i,
  input  logic             pending_i,
  input  logic             ovr_i,
  input  logic [CNT_W-1:0] bufs_i,
  input  logic [CNT_W-1:0] frames_i,
  input  logic [CNT_W-1:0] bytes_i,
  input  logic             in_valid_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_first_o,
  output logic             out_last_o,
  output logic [31:0]      out_data_o,
  input  logic             out_ready_i,
  output logic             snap_o,
  output logic             drop_frame_o,
  output logic             drop_word_o,
  output logic             rpt_active_o
);
  localparam logic [2:0] LAST_W = 3'(RPT_WORDS - 1);

  ins_state_e state_q;
  logic [2:0]  cnt_q;
  logic        drop_q;
  logic [63:0] time_q;
  logic [31:0] bufs_q, frames_q, bytes_q;
  logic [31:0] rpt_word;

  always_comb begin
    unique case (cnt_q)
      3'd0:    rpt_word = time_q[63:32];
      3'd1:    rpt_word = time_q[31:0];
      3'd2:    rpt_word = RPT_STATUS;
      3'd3:    rpt_word = bufs_q;
      3'd4:    rpt_word = frames_q;
      default: rpt_word = bytes_q;
    endcase
  end

  always_comb begin
    in_ready_o   = 1'b0;
    out_valid_o  = 1'b0;
    out_first_o  = 1'b0;
    out_last_o   = 1'b0;
    out_data_o   = '0;
    snap_o       = 1'b0;
    drop_frame_o = 1'b0;
    drop_word_o  = 1'b0;
    if (state_q == ST_RPT) begin
      out_valid_o = 1'b1;
      out_first_o = (cnt_q == 3'd0);
      out_last_o  = (cnt_q == LAST_W);
      out_data_o  = rpt_word;
    end else if (in_valid_i) begin
      if (in_first_i && pending_i && !ovr_i) begin
        snap_o = 1'b1;
      end else if (in_first_i ? ovr_i : drop_q) begin
        in_ready_o   = 1'b1;
        drop_word_o  = 1'b1;
        drop_frame_o = in_first_i;
      end else begin
        out_valid_o = 1'b1;
        out_first_o = in_first_i;
        out_last_o  = in_last_i;
        out_data_o  = in_data_i;
        in_ready_o  = out_ready_i;
      end
    end
  end

  assign rpt_active_o = (state_q == ST_RPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PASS;
      cnt_q    <= '0;
      drop_q   <= 1'b0;
      time_q   <= '0;
      bufs_q   <= '0;
      frames_q <= '0;
      bytes_q  <= '0;
    end else begin
      if (snap_o) begin
        state_q  <= ST_RPT;
        cnt_q    <= '0;
        time_q   <= time_i;
        bufs_q   <= 32'(bufs_i);
        frames_q <= 32'(frames_i);
        bytes_q  <= 32'(bytes_i);
      end else if (state_q == ST_RPT && out_ready_i) begin
        if (cnt_q == LAST_W) state_q <= ST_PASS;
        else                 cnt_q   <= cnt_q + 3'd1;
      end
      if (state_q == ST_PASS && in_valid_i && in_ready_o && in_first_i)
        drop_q <= ovr_i;
    end
  end
endmodule

// File: rtl/ring_flow_ctrl.sv
module ring_flow_ctrl #(
  parameter  int unsigned RING_MAX = 512,
  parameter  int unsigned CNT_W    = 32,
  localparam int unsigned IDX_W    = $clog2(RING_MAX),
  localparam int unsigned SZ_W     = $clog2(RING_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      time_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             buf_req_i,
  input  logic             xfer_done_i,
  output logic             xfer_start_o,
  output logic [IDX_W-1:0] xfer_idx_o,
  output logic             irq_o,
  input  logic             in_valid_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_first_o,
  output logic             out_last_o,
  output logic [31:0]      out_data_o,
  input  logic             out_ready_i
);
  logic             lost, space, snap, drop_frame, drop_word;
  logic             ovr_active, pending, rpt_active;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] bufs_cnt, frames_cnt, bytes_cnt;

  ring_idx_unit #(.RING_MAX(RING_MAX), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_idx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .buf_req_i   (buf_req_i),
    .xfer_done_i (xfer_done_i),
    .xfer_start_o(xfer_start_o),
    .xfer_idx_o  (xfer_idx_o),
    .irq_o       (irq_o),
    .lost_o      (lost),
    .space_o     (space),
    .rd_idx_o    (rd_idx)
  );

  loss_acct #(.CNT_W(CNT_W)) u_loss (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lost_i      (lost),
    .space_i     (space),
    .drop_frame_i(drop_frame),
    .drop_word_i (drop_word),
    .snap_i      (snap),
    .bufs_o      (bufs_cnt),
    .frames_o    (frames_cnt),
    .bytes_o     (bytes_cnt),
    .ovr_o       (ovr_active),
    .pending_o   (pending)
  );

  stream_insert #(.CNT_W(CNT_W)) u_ins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .time_i      (time_i),
    .pending_i   (pending),
    .ovr_i       (ovr_active),
    .bufs_i      (bufs_cnt),
    .frames_i    (frames_cnt),
    .bytes_i     (bytes_cnt),
    .in_valid_i  (in_valid_i),
    .in_first_i  (in_first_i),
    .in_last_i   (in_last_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_first_o (out_first_o),
    .out_last_o  (out_last_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .snap_o      (snap),
    .drop_frame_o(drop_frame),
    .drop_word_o (drop_word),
    .rpt_active_o(rpt_active)
  );
endmodule

// File: rtl/ring_flow_chk.sv
module ring_flow_chk #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_start_o,
  input logic [IDX_W-1:0] xfer_idx_o,
  input logic             xfer_done_i,
  input logic             irq_o,
  input logic             in_valid_i,
  input logic             in_first_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [31:0]      out_data_o,
  input logic [IDX_W-1:0] rd_idx,
  input logic             ovr_active,
  input logic             rpt_active,
  input logic             snap,
  input logic [CNT_W-1:0] frames_cnt
);
  // R3
  start_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (xfer_idx_o != rd_idx));

  // R5
  start_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  // R4
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(xfer_done_i));

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R6
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_active && !rpt_active && in_valid_i && in_first_i) |-> (!out_valid_o && in_ready_o));

  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_active |-> !in_ready_o);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_active && out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R7
  mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap |=> (frames_cnt >= $past(frames_cnt)));
endmodule

bind ring_flow_ctrl ring_flow_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_start_o(xfer_start_o),
  .xfer_idx_o  (xfer_idx_o),
  .xfer_done_i (xfer_done_i),
  .irq_o       (irq_o),
  .in_valid_i  (in_valid_i),
  .in_first_i  (in_first_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .rd_idx      (rd_idx),
  .ovr_active  (ovr_active),
  .rpt_active  (rpt_active),
  .snap        (snap),
  .frames_cnt  (frames_cnt)
);

// File: tb/ring_flow_ctrl_test.sv
module ring_flow_ctrl_test;
  localparam logic [63:0] TNOW = 64'h0000_00AB_1234_5678;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] time_i = TNOW;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        buf_req_i = 1'b0, xfer_done_i = 1'b0;
  logic        xfer_start_o, irq_o;
  logic [2:0]  xfer_idx_o;
  logic        in_valid_i = 1'b0, in_first_i = 1'b0, in_last_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o, out_valid_o, out_first_o, out_last_o;
  logic [31:0] out_data_o;
  logic        out_ready_i = 1'b1;

  int checks = 0, errors = 0;
  logic [31:0] oq_d [0:255];
  logic        oq_f [0:255];
  logic        oq_l [0:255];
  int oq_n = 0;

  always #2.5 clk = ~clk;

  ring_flow_ctrl #(.RING_MAX(8), .CNT_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(time_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .buf_req_i(buf_req_i), .xfer_done_i(xfer_done_i), .xfer_start_o(xfer_start_o),
    .xfer_idx_o(xfer_idx_o), .irq_o(irq_o),
    .in_valid_i(in_valid_i), .in_first_i(in_first_i), .in_last_i(in_last_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_first_o(out_first_o),
    .out_last_o(out_last_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  always @(negedge clk) begin
    if (out_valid_o && out_ready_i && oq_n < 256) begin
      oq_d[oq_n] = out_data_o;
      oq_f[oq_n] = out_first_o;
      oq_l[oq_n] = out_last_o;
      oq_n = oq_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic do_buf(input logic exp_start, input logic [2:0] exp_idx, input string req);
    logic s; logic [2:0] idx;
    @(posedge clk); #1; buf_req_i = 1'b1;
    @(negedge clk); s = xfer_start_o; idx = xfer_idx_o;
    @(posedge clk); #1; buf_req_i = 1'b0;
    check(req, s, exp_start);
    if (s) begin
      check(req, idx, exp_idx);
      xfer_done_i = 1'b1;
      @(posedge clk); #1; xfer_done_i = 1'b0;
      @(negedge clk); check("R4", irq_o, 1'b1);
      @(negedge clk); check("R4", irq_o, 1'b0);
    end else begin
      @(negedge clk); check(req, irq_o, 1'b0);
    end
  endtask

  task automatic send_frame(input int n, input logic [31:0] base);
    logic acc;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid_i = 1'b1; in_first_i = (i == 0); in_last_i = (i == n - 1); in_data_i = base + 32'(i);
      do begin
        @(negedge clk); acc = in_ready_o;
        @(posedge clk); #1;
      end while (!acc);
      in_valid_i = 1'b0; in_first_i = 1'b0; in_last_i = 1'b0;
    end
  endtask

  task automatic check_rpt(input int k, input logic [31:0] b, input logic [31:0] f, input logic [31:0] y);
    check("R9", oq_d[k],   TNOW[63:32]);
    check("R9", oq_d[k+1], TNOW[31:0]);
    check("R9", oq_d[k+2], 32'h2000_000C);
    check("R9", {oq_f[k], oq_l[k+5]}, 2'b11);
    check("R5", oq_d[k+3], b);
    check("R6", oq_d[k+4], f);
    check("R6", oq_d[k+5], y);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(2'd0, d); check("R1", d, 32'd8);
    reg_rd(2'd1, d); check("R1", d, 32'd0);
    reg_rd(2'd2, d); check("R1", d, 32'd0);
    check("R1", {xfer_start_o, irq_o}, 2'b00);
    reg_rd(2'd3, d); check("R2", d, 32'd0);
  endtask

  task automatic t_size();
    logic [31:0] d;
    reg_wr(2'd0, 32'd1);   reg_rd(2'd0, d); check("R2", d, 32'd2);
    reg_wr(2'd0, 32'd100); reg_rd(2'd0, d); check("R2", d, 32'd8);
    reg_wr(2'd0, 32'd4);   reg_rd(2'd0, d); check("R2", d, 32'd4);
    reg_wr(2'd1, 32'd9);   reg_rd(2'd1, d); check("R2", d, 32'd0);
    reg_wr(2'd2, 32'd3);   reg_rd(2'd2, d); check("R2", d, 32'd0);
  endtask

  task automatic t_pass();
    int n0 = oq_n;
    send_frame(3, 32'hA000_0000);
    check("R11", oq_n - n0, 3);
    check("R11", oq_d[n0], 32'hA000_0000);
    check("R11", oq_d[n0+2], 32'hA000_0002);
    check("R11", {oq_f[n0], oq_l[n0], oq_l[n0+2]}, 3'b101);
  endtask

  task automatic t_fill_drop();
    logic [31:0] d; int n0;
    do_buf(1'b1, 3'd1, "R3");
    do_buf(1'b1, 3'd2, "R3");
    do_buf(1'b1, 3'd3, "R3");
    reg_rd(2'd2, d); check("R4", d, 32'd3);
    do_buf(1'b0, 3'd0, "R5");
    n0 = oq_n;
    send_frame(1, 32'hB000_0000);
    send_frame(2, 32'hB100_0000);
    check("R6", oq_n - n0, 0);
    reg_wr(2'd1, 32'd2);
    repeat (3) @(posedge clk);
    check("R9", oq_n - n0, 0);
    send_frame(2, 32'hC000_0000);
    check("R9", oq_n - n0, 8);
    check_rpt(n0, 32'd1, 32'd2, 32'd12);
    check("R8", oq_d[n0+6], 32'hC000_0000);
    check("R8", oq_d[n0+7], 32'hC000_0001);
    do_buf(1'b1, 3'd0, "R3");
  endtask

  task automatic t_busy_sat();
    int n0; logic s2;
    @(posedge clk); #1; buf_req_i = 1'b1;
    @(negedge clk); check("R3", {xfer_start_o, xfer_idx_o}, {1'b1, 3'd1});
    @(posedge clk); #1;
    @(negedge clk); s2 = xfer_start_o;
    @(posedge clk); #1; buf_req_i = 1'b0;
    check("R5", s2, 1'b0);
    xfer_done_i = 1'b1;
    @(posedge clk); #1; xfer_done_i = 1'b0;
    n0 = oq_n;
    for (int i = 0; i < 20; i++) send_frame(1, 32'hD000_0000 + 32'(i));
    check("R6", oq_n - n0, 0);
    reg_wr(2'd1, 32'd1);
    repeat (2) @(posedge clk); #1;
    out_ready_i = 1'b0;
    fork
      send_frame(1, 32'hE000_0000);
      begin
        logic [31:0] h;
        repeat (3) @(negedge clk);
        h = out_data_o;
        repeat (3) @(negedge clk);
        check("R12", {out_valid_o, in_ready_o}, 2'b10);
        check("R12", out_data_o, h);
        check("R12", out_data_o, TNOW[63:32]);
        @(posedge clk); #1; out_ready_i = 1'b1;
      end
    join
    check("R9", oq_n - n0, 7);
    check_rpt(n0, 32'd1, 32'd15, 32'd15);
    check("R7", oq_d[n0+4], 32'd15);
    check("R7", oq_d[n0+5], 32'd15);
    check("R9", oq_d[n0+6], 32'hE000_0000);
  endtask

  task automatic t_clear();
    int n0;
    do_buf(1'b1, 3'd2, "R3");
    do_buf(1'b1, 3'd3, "R3");
    do_buf(1'b1, 3'd0, "R3");
    do_buf(1'b0, 3'd0, "R5");
    n0 = oq_n;
    send_frame(1, 32'hF000_0000);
    reg_wr(2'd1, 32'd0);
    repeat (2) @(posedge clk);
    send_frame(1, 32'hF100_0000);
    check("R10", oq_n - n0, 7);
    check_rpt(n0, 32'd1, 32'd1, 32'd4);
    check("R10", oq_d[n0+6], 32'hF100_0000);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_ni = 1'b1;
    t_reset();
    t_size();
    t_pass();
    t_fill_drop();
    t_busy_sat();
    t_clear();
    done = 1'b1;
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule